// File: doc/BRIEF.md
# Pad Wakeup Pattern Detector

This block is a single wakeup detector clocked by the always-on clock. It watches one pad bit that has already been routed to it and looks for a programmed pattern. The pattern can be a rising edge, a falling edge, an edge of either polarity, or a level held high or held low for a programmed number of always-on cycles. When the pattern is found, a sticky cause bit is set. The wakeup request output follows that bit. Software clears the bit by writing 0 to it.

An optional debounce stage can sit in front of the detection logic. With the stage on, a new pad level is passed on only after it has been sampled unchanged on four consecutive always-on edges. The pad bit is always registered once before detection. Without the filter, a pad change therefore becomes visible to detection one edge after it is driven.

The configuration inputs (enable, mode, filter on, threshold) are assumed to be already synchronous to the always-on clock. The pulse-width counter is deliberately left alone when the mode is changed while the detector is enabled. Software should disable the detector before it reprograms the mode.

Top module: `wake_pattern_detect`

## Requirements
- R1: After reset the cause bit and the wakeup request are both 0.
- R2: Mode code 0 detects a rising edge. A pad rise first sampled at clock edge k sets the cause at edge k+1, and a falling edge sets nothing.
- R3: Mode code 1 detects a falling edge with the same latency as R2, and a rising edge sets nothing.
- R4: Mode code 2 detects an edge of either polarity with the same latency as R2.
- R5: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R6: Mode code 3 is timed-high with threshold T (8 bits). The pad is first sampled high at edge k and stays high. The cause is then set at edge k+T+1 and not before. A high pulse that lasts T cycles or fewer sets nothing.
- R7: Mode code 4 is timed-low and mirrors R6 for a low level. With T = 0 the cause is set on the first edge at which the level matches while the detector is enabled.
- R8: The pulse-width counter restarts from zero when the sampled level stops matching the target level of the mode, or when the detector is disabled. Changing the mode does not clear the counter. Modes 3 and 4 target high and low respectively, and every other mode code targets high.
- R9: With the filter on, a new pad value reaches detection only after four consecutive equal samples. A level first sampled at edge k is seen by detection from edge k+4, so a rising edge in mode 0 sets the cause at edge k+5. A pulse of three cycles or fewer is discarded.
- R10: While enable is 0 the cause is never set. Turning enable on while the pad is already at a steady level produces no edge.
- R11: The cause stays 1 until a write with data 0 occurs (write strobe 1, data 0), which clears it on the next edge. A write with data 1 has no effect. A detection in the same cycle as a clearing write leaves the cause at 1.
- R12: The wakeup request always equals the cause bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkAon | input | 1 | Always-on clock |
| rstAonN | input | 1 | Active-low asynchronous reset |
| padBit | input | 1 | Selected pad level |
| cfgEnable | input | 1 | Detector enable |
| cfgMode | input | 3 | Detection mode code (see R2 to R7) |
| cfgFilter | input | 1 | 1 turns the four-sample debounce on |
| cfgThresh | input | 8 | Cycle threshold for the timed modes |
| causeWe | input | 1 | Software write strobe for the cause bit |
| causeWdata | input | 1 | Write data; 0 clears the cause |
| wakeReq | output | 1 | Wakeup request |
| causeOut | output | 1 | Sticky cause bit |

## Verification
The assertions check four properties on every clock cycle:
- the cause stays set unless a clearing write occurs;
- the cause never rises while the detector is disabled;
- a qualified rising edge or a reached threshold is followed by a set cause;
- the counter clears or steps exactly as the control strobes ask.

Other behaviours depend on a history of stimulus, and only the bench scenarios can show them:
- the exact latency through the debounce stage;
- a glitch being discarded;
- the counter surviving a mode change but restarting after a level mismatch;
- the absence of a false edge when the detector is enabled.

// File: rtl/wkdet_pkg.sv
package wkdet_pkg;

  parameter int unsigned DefThreshW  = 8;
  parameter int unsigned DefFiltTaps = 4;

  typedef enum logic [2:0] {
    DetRise  = 3'd0,
    DetFall  = 3'd1,
    DetAny   = 3'd2,
    DetHigh  = 3'd3,
    DetLow   = 3'd4
  } detMode_e;

  // Strobes sent from control to datapath every cycle.
  typedef struct packed {
    logic useFilter;
    logic cntClr;
    logic cntInc;
  } detStrobe_t;

endpackage

// File: rtl/wkdet_datapath.sv
module wkdet_datapath
  import wkdet_pkg::*;
#(
  parameter int unsigned ThreshW  = DefThreshW,
  parameter int unsigned FiltTaps = DefFiltTaps
) (
  input  logic               clkAon,
  input  logic               rstAonN,
  input  logic               padBit,
  input  detStrobe_t         stb,
  output logic               curBit,
  output logic               prevBit,
  output logic [ThreshW-1:0] pulseCnt
);

  localparam logic [ThreshW-1:0] CntMax = {ThreshW{1'b1}};

  logic [FiltTaps-1:0] sampleHist;
  logic                filtQ;
  logic                prevQ;
  logic [ThreshW-1:0]  cntQ;

  // Sample history: tap 0 is the most recent registered pad level.
  always_ff @(posedge clkAon or negedge rstAonN) begin
    if (!rstAonN) begin
      sampleHist <= '0;
    end else begin
      sampleHist <= {sampleHist[FiltTaps-2:0], padBit};
    end
  end

  // Debounced level: moves only when all taps agree.
  always_ff @(posedge clkAon or negedge rstAonN) begin
    if (!rstAonN) begin
      filtQ <= 1'b0;
    end else if (&sampleHist) begin
      filtQ <= 1'b1;
    end else if (~|sampleHist) begin
      filtQ <= 1'b0;
    end
  end

  assign curBit = stb.useFilter ? filtQ : sampleHist[0];

  // The previous sample tracks the current one even while the detector is off,
  // so enabling it compares two real samples and cannot see a false edge.
  always_ff @(posedge clkAon or negedge rstAonN) begin
    if (!rstAonN) begin
      prevQ <= 1'b0;
    end else begin
      prevQ <= curBit;
    end
  end

  assign prevBit = prevQ;

  // Saturating pulse-width counter.
  always_ff @(posedge clkAon or negedge rstAonN) begin
    if (!rstAonN) begin
      cntQ <= '0;
    end else if (stb.cntClr) begin
      cntQ <= '0;
    end else if (stb.cntInc && (cntQ != CntMax)) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign pulseCnt = cntQ;

  // R8: a clear strobe from control empties the counter on the next edge
  p_cnt_clear_r8 : assert property (@(posedge clkAon) disable iff (!rstAonN)
    stb.cntClr |=> (pulseCnt == '0));

  // R6: an increment strobe below saturation advances the counter by one
  p_cnt_step_r6 : assert property (@(posedge clkAon) disable iff (!rstAonN)
    (stb.cntInc && !stb.cntClr && (pulseCnt != CntMax))
      |=> (pulseCnt == ThreshW'($past(pulseCnt) + 1'b1)));

endmodule

// File: rtl/wkdet_ctrl.sv
module wkdet_ctrl
  import wkdet_pkg::*;
#(
  parameter int unsigned ThreshW = DefThreshW
) (
  input  logic               clkAon,
  input  logic               rstAonN,
  input  logic               cfgEnable,
  input  logic [2:0]         cfgMode,
  input  logic               cfgFilter,
  input  logic [ThreshW-1:0] cfgThresh,
  input  logic               causeWe,
  input  logic               causeWdata,
  input  logic               curBit,
  input  logic               prevBit,
  input  logic [ThreshW-1:0] pulseCnt,
  output detStrobe_t         stb,
  output logic               causeQ
);

  detMode_e effMode;
  logic     levelMatch;
  logic     timedMode;
  logic     edgeHit;
  logic     timedHit;
  logic     patternHit;
  logic     swClear;

  // Out-of-range codes fall back to rising-edge detection.
  always_comb begin
    case (cfgMode)
      3'd1:    effMode = DetFall;
      3'd2:    effMode = DetAny;
      3'd3:    effMode = DetHigh;
      3'd4:    effMode = DetLow;
      default: effMode = DetRise;
    endcase
  end

  // Only the timed-low mode targets a low level; the counter keeps its value
  // across a mode change as long as the target level still matches.
  assign levelMatch = (effMode == DetLow) ? !curBit : curBit;
  assign timedMode  = (effMode == DetHigh) || (effMode == DetLow);

  always_comb begin
    case (effMode)
      DetFall: edgeHit = prevBit && !curBit;
      DetAny:  edgeHit = prevBit ^ curBit;
      DetRise: edgeHit = !prevBit && curBit;
      default: edgeHit = 1'b0;
    endcase
  end

  assign timedHit   = timedMode && levelMatch && (pulseCnt >= cfgThresh);
  assign patternHit = cfgEnable && (edgeHit || timedHit);

  always_comb begin
    stb           = '0;
    stb.useFilter = cfgFilter;
    stb.cntClr    = !cfgEnable || !levelMatch;
    stb.cntInc    = cfgEnable && levelMatch;
  end

  assign swClear = causeWe && !causeWdata;

  // Sticky cause: a detection wins over a clearing write in the same cycle.
  always_ff @(posedge clkAon or negedge rstAonN) begin
    if (!rstAonN) begin
      causeQ <= 1'b0;
    end else if (patternHit) begin
      causeQ <= 1'b1;
    end else if (swClear) begin
      causeQ <= 1'b0;
    end
  end

  // R11: only a write of 0 can drop the cause
  p_sticky_r11 : assert property (@(posedge clkAon) disable iff (!rstAonN)
    (causeQ && !(causeWe && !causeWdata)) |=> causeQ);

  // R10: a disabled detector never raises the cause
  p_idle_when_off_r10 : assert property (@(posedge clkAon) disable iff (!rstAonN)
    (!cfgEnable && !causeQ) |=> !causeQ);

  // R2: a qualified rising edge in mode 0 sets the cause
  p_rise_hit_r2 : assert property (@(posedge clkAon) disable iff (!rstAonN)
    (cfgEnable && (cfgMode == 3'd0) && curBit && !prevBit) |=> causeQ);

  // R6: a high level held to the threshold sets the cause
  p_timed_hit_r6 : assert property (@(posedge clkAon) disable iff (!rstAonN)
    (cfgEnable && (cfgMode == 3'd3) && curBit && (pulseCnt >= cfgThresh)) |=> causeQ);

endmodule

// File: rtl/wake_pattern_detect.sv
module wake_pattern_detect
  import wkdet_pkg::*;
#(
  parameter int unsigned ThreshW  = DefThreshW,
  parameter int unsigned FiltTaps = DefFiltTaps
) (
  input  logic               clkAon,
  input  logic               rstAonN,
  input  logic               padBit,
  input  logic               cfgEnable,
  input  logic [2:0]         cfgMode,
  input  logic               cfgFilter,
  input  logic [ThreshW-1:0] cfgThresh,
  input  logic               causeWe,
  input  logic               causeWdata,
  output logic               wakeReq,
  output logic               causeOut
);

  detStrobe_t         stb;
  logic               curBit;
  logic               prevBit;
  logic [ThreshW-1:0] pulseCnt;
  logic               causeQ;

  wkdet_datapath #(
    .ThreshW  (ThreshW),
    .FiltTaps (FiltTaps)
  ) i_datapath (
    .clkAon   (clkAon),
    .rstAonN  (rstAonN),
    .padBit   (padBit),
    .stb      (stb),
    .curBit   (curBit),
    .prevBit  (prevBit),
    .pulseCnt (pulseCnt)
  );

  wkdet_ctrl #(
    .ThreshW (ThreshW)
  ) i_ctrl (
    .clkAon     (clkAon),
    .rstAonN    (rstAonN),
    .cfgEnable  (cfgEnable),
    .cfgMode    (cfgMode),
    .cfgFilter  (cfgFilter),
    .cfgThresh  (cfgThresh),
    .causeWe    (causeWe),
    .causeWdata (causeWdata),
    .curBit     (curBit),
    .prevBit    (prevBit),
    .pulseCnt   (pulseCnt),
    .stb        (stb),
    .causeQ     (causeQ)
  );

  assign causeOut = causeQ;
  assign wakeReq  = causeQ;

endmodule

// File: tb/test_wake_pattern_detect.sv
`timescale 1ns/1ps
module test_wake_pattern_detect;

  logic       clkAon = 1'b0;
  logic       rstAonN = 1'b0;
  logic       padBit = 1'b0;
  logic       cfgEnable = 1'b0;
  logic [2:0] cfgMode = 3'd0;
  logic       cfgFilter = 1'b0;
  logic [7:0] cfgThresh = 8'd0;
  logic       causeWe = 1'b0;
  logic       causeWdata = 1'b0;
  logic       wakeReq;
  logic       causeOut;

  int cycNow = 0;
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    int    cyc;
    bit    val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clkAon = ~clkAon;

  always @(posedge clkAon) cycNow <= cycNow + 1;

  wake_pattern_detect i_wake_pattern_detect (
    .clkAon     (clkAon),
    .rstAonN    (rstAonN),
    .padBit     (padBit),
    .cfgEnable  (cfgEnable),
    .cfgMode    (cfgMode),
    .cfgFilter  (cfgFilter),
    .cfgThresh  (cfgThresh),
    .causeWe    (causeWe),
    .causeWdata (causeWdata),
    .wakeReq    (wakeReq),
    .causeOut   (causeOut)
  );

  // Monitor: compares outputs at the falling edge against queued expectations.
  always @(negedge clkAon) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cycNow) begin
      expItem_t it;
      it = expQ.pop_front();
      checkCnt++;
      if (causeOut !== it.val) begin
        failCnt++;
        $display("FAIL %s cycle %0d: causeOut actual=%b expected=%b", it.tag, cycNow, causeOut, it.val);
      end
      checkCnt++;
      if (wakeReq !== it.val) begin
        failCnt++;
        $display("FAIL R12 (%s) cycle %0d: wakeReq actual=%b expected=%b", it.tag, cycNow, wakeReq, it.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clkAon);
    #1;
  endtask

  task automatic expectAt(input int off, input bit val, input string tag);
    expItem_t it;
    it.cyc = cycNow + off;
    it.val = val;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic clearCause();
    causeWe = 1'b1;
    causeWdata = 1'b0;
    tick(1);
    causeWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clkAon);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    tick(3);
    rstAonN = 1'b1;

    // R1: reset state
    expectAt(1, 1'b0, "R1 reset state");
    tick(2);

    // R2: rising edge, latency two edges after driving
    cfgEnable = 1'b1; cfgMode = 3'd0;
    tick(3);
    padBit = 1'b1;
    expectAt(1, 1'b0, "R2 before latency");
    expectAt(2, 1'b1, "R2 rising edge");
    tick(3);
    padBit = 1'b0;
    tick(3);
    // R11: sticky, write 1 ignored, write 0 clears
    expectAt(1, 1'b1, "R11 sticky");
    causeWe = 1'b1; causeWdata = 1'b1;
    expectAt(1, 1'b1, "R11 write of 1 ignored");
    tick(1);
    causeWe = 1'b1; causeWdata = 1'b0;
    expectAt(1, 1'b0, "R11 write of 0 clears");
    tick(1);
    causeWe = 1'b0;
    tick(2);

    // R3: falling edge only
    cfgMode = 3'd1;
    padBit = 1'b1;
    expectAt(2, 1'b0, "R3 rise ignored");
    tick(3);
    padBit = 1'b0;
    expectAt(1, 1'b0, "R3 before latency");
    expectAt(2, 1'b1, "R3 falling edge");
    tick(3);
    clearCause();
    tick(1);

    // R4: either edge
    cfgMode = 3'd2;
    padBit = 1'b1;
    expectAt(2, 1'b1, "R4 rise");
    tick(3);
    clearCause();
    tick(2);
    padBit = 1'b0;
    expectAt(2, 1'b1, "R4 fall");
    tick(3);
    clearCause();
    tick(2);

    // R5: code 6 acts as rising edge
    cfgMode = 3'd6;
    padBit = 1'b1;
    expectAt(2, 1'b1, "R5 code 6 rising");
    tick(3);
    clearCause();
    tick(1);
    padBit = 1'b0;
    expectAt(2, 1'b0, "R5 code 6 fall ignored");
    tick(3);

    // R6: timed high, threshold 5
    cfgEnable = 1'b0; cfgMode = 3'd3; cfgThresh = 8'd5;
    tick(2);
    cfgEnable = 1'b1;
    tick(2);
    padBit = 1'b1;
    expectAt(6, 1'b0, "R6 before threshold");
    expectAt(7, 1'b1, "R6 threshold reached");
    tick(8);
    padBit = 1'b0;
    tick(3);
    clearCause();
    tick(2);
    padBit = 1'b1;
    expectAt(8, 1'b0, "R6 short pulse ignored");
    tick(4);
    padBit = 1'b0;
    tick(6);

    // R7: timed low with threshold 0, then threshold 3
    cfgEnable = 1'b0; cfgMode = 3'd4; cfgThresh = 8'd0;
    tick(1);
    cfgEnable = 1'b1;
    expectAt(1, 1'b1, "R7 threshold 0 fires at once");
    tick(2);
    cfgEnable = 1'b0;
    padBit = 1'b1;
    tick(1);
    clearCause();
    cfgThresh = 8'd3;
    cfgEnable = 1'b1;
    tick(3);
    padBit = 1'b0;
    expectAt(4, 1'b0, "R7 before threshold");
    expectAt(5, 1'b1, "R7 low held to threshold");
    tick(6);
    padBit = 1'b1;
    cfgEnable = 1'b0;
    tick(2);
    clearCause();
    tick(1);

    // R8: counter survives a mode change
    cfgMode = 3'd3; cfgThresh = 8'd6;
    padBit = 1'b0;
    cfgEnable = 1'b1;
    tick(2);
    padBit = 1'b1;
    expectAt(7, 1'b0, "R8 before threshold");
    expectAt(8, 1'b1, "R8 count kept across mode change");
    tick(3);
    cfgMode = 3'd0;
    tick(2);
    cfgMode = 3'd3;
    tick(4);
    padBit = 1'b0;
    tick(2);
    clearCause();
    tick(1);
    // R8: counter restarts after a level mismatch
    padBit = 1'b1;
    expectAt(12, 1'b0, "R8 mismatch restarts count");
    expectAt(13, 1'b1, "R8 fires after full restart");
    tick(4);
    padBit = 1'b0;
    tick(1);
    padBit = 1'b1;
    tick(10);
    cfgEnable = 1'b0;
    padBit = 1'b0;
    tick(1);
    clearCause();

    // R9: debounce filter
    cfgMode = 3'd0; cfgFilter = 1'b1;
    tick(6);
    cfgEnable = 1'b1;
    tick(2);
    padBit = 1'b1;
    expectAt(8, 1'b0, "R9 glitch discarded");
    tick(3);
    padBit = 1'b0;
    tick(6);
    padBit = 1'b1;
    expectAt(5, 1'b0, "R9 filter latency not yet");
    expectAt(6, 1'b1, "R9 stable level passed");
    tick(7);
    cfgFilter = 1'b0;
    cfgEnable = 1'b0;
    padBit = 1'b0;
    tick(2);
    clearCause();
    tick(1);

    // R10: disabled detector ignores edges; enabling makes no false edge
    padBit = 1'b1;
    expectAt(3, 1'b0, "R10 disabled ignores edge");
    tick(4);
    cfgEnable = 1'b1;
    expectAt(2, 1'b0, "R10 enable gives no false edge");
    tick(3);

    // R11: detection wins over a simultaneous clear
    padBit = 1'b0;
    tick(2);
    padBit = 1'b1;
    tick(1);
    causeWe = 1'b1; causeWdata = 1'b0;
    expectAt(1, 1'b1, "R11 set wins over clear");
    tick(1);
    causeWe = 1'b0;
    tick(3);

    finished = 1'b1;
    finishRun();
  end

endmodule